// File: doc/BRIEF.md
# Chainable byte FIFO with ownership tokens

This block is a single-clock FIFO built from a ring of identical storage slices. Each slice holds a fixed number of bytes. Two ownership tokens travel around the ring. The write token marks the one slice that takes incoming words. The read token marks the one slice that supplies outgoing words. When the token holder uses its last physical location, it passes that token to the next slice over a two-bit expansion link. The ring as a whole therefore behaves as one FIFO whose depth is the slice depth times the slice count. Slice 0 is the first-load slice: it holds both tokens after reset, and no other slice holds either.

Each slice produces active-low empty, full and half-full flags. The top combines them. The composite empty is asserted only when every slice is empty, and the composite full is asserted only when every slice is full. The stream edges use valid/ready. `in_ready` is the inverse of the composite full flag, and `out_valid` is the inverse of the composite empty flag. A word moves in on a cycle where `in_valid && in_ready` holds, and moves out on a cycle where `out_valid && out_ready` holds. Back-pressure is taken from the registered flags only. A word offered while the FIFO is full is dropped, not held. Likewise, a read request made while the FIFO is empty is not queued. Both `in_valid` and `out_ready` act as strobes.

With one slice (`SLICES = 1`) the block runs in single-slice mode. In that mode the half-full flag is active, and a retransmit pulse rewinds the read side to the first physical location. In a ring of more than one slice, both of those features are disabled.

Top module: `cfifo_chain`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `half_n` is 1.
- R2: Words leave `out_data` in the order they were accepted. While `out_valid` is 1, `out_data` shows the oldest stored word.
- R3: `in_ready` falls after exactly `SLICES*SLICE_DEPTH` accepted words with no read. A word offered while `in_ready` is 0 is not stored, even if a read is accepted in the same cycle.
- R4: A read request while `out_valid` is 0 removes nothing, even if a write is accepted in the same cycle.
- R5: Read flow-through. A word written into an empty FIFO makes `out_valid` 1 on the next cycle, carrying that word. After that word is read, `out_valid` returns to 0 on the next cycle.
- R6: Write flow-through. A read from a full FIFO makes `in_ready` 1 on the next cycle. One further accepted write makes it 0 again.
- R7: Exactly one slice holds the write token and exactly one holds the read token at all times. Each token moves to the next slice, in ring order, when its holder uses its last physical location. Ordering is therefore preserved across slice boundaries.
- R8: In single-slice mode, `half_n` is 0 exactly when the stored count exceeds half of `SLICE_DEPTH`. With more than one slice, `half_n` stays 1.
- R9: In single-slice mode, a cycle with `retx` high sets the read position to physical location 0 and the stored count to the write position. Write and read strobes are ignored in that cycle.
- R10: With more than one slice, `retx` has no effect. Reads and writes proceed as if it were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Write strobe / input valid |
| in_ready | output | 1 | Not full (inverse of composite full flag) |
| in_data | input | WIDTH | Word to store |
| out_valid | output | 1 | Not empty (inverse of composite empty flag) |
| out_ready | input | 1 | Read strobe / output ready |
| out_data | output | WIDTH | Oldest stored word |
| half_n | output | 1 | Half-full flag, active low, single-slice mode only |
| retx | input | 1 | Retransmit pulse, single-slice mode only |

## Verification
On every cycle, the assertions check four things. Each token stays unique. Both flow-through recoveries happen one cycle after the enabling transfer. A flag only falls after the strobe that could cause it. `half_n` stays high in a ring. The bench's queue model is needed to show the rest: word order across slice boundaries, the exact capacity, dropped writes at full and refused reads at empty, and the replayed contents after a retransmit. Those need the history of the data, not single-cycle relations.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  // One bit per token; a pulse hands that token to the next slice in the ring.
  typedef struct packed {
    logic wpass;
    logic rpass;
  } xtok_t;
endpackage

// File: rtl/cfifo_store.sv
module cfifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cfifo_slice.sv
module cfifo_slice
  import cfifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             solo,
  input  logic             first_n,
  input  xtok_t            xi,
  output xtok_t            xo,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  input  logic             retx,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             own_w,
  output logic             own_r
);
  localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0]   CNT_HALF = (AW+1)'(DEPTH / 2);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          rewind, wfire, rfire, wlast, rlast;
  logic          tok_w, tok_r;

  assign rewind = solo & retx;
  assign wfire  = wr & own_w & (cnt != CNT_FULL) & ~rewind;
  assign rfire  = rd & own_r & (cnt != '0) & ~rewind;
  assign wlast  = (wptr == LAST);
  assign rlast  = (rptr == LAST);

  assign xo.wpass = wfire & wlast;
  assign xo.rpass = rfire & rlast;

  // Single-slice mode owns both tokens permanently.
  assign own_w = solo | tok_w;
  assign own_r = solo | tok_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_w <= ~first_n;
      tok_r <= ~first_n;
    end else begin
      if (tok_w && xo.wpass)  tok_w <= 1'b0;
      else if (xi.wpass)      tok_w <= 1'b1;
      if (tok_r && xo.rpass)  tok_r <= 1'b0;
      else if (xi.rpass)      tok_r <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (rewind) begin
      rptr <= '0;
      cnt  <= {1'b0, wptr};
    end else begin
      if (wfire) wptr <= wlast ? '0 : wptr + 1'b1;
      if (rfire) rptr <= rlast ? '0 : rptr + 1'b1;
      case ({wfire, rfire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign empty_n = (cnt != '0);
  assign full_n  = (cnt != CNT_FULL);
  assign half_n  = ~(solo & (cnt > CNT_HALF));

  cfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wfire),
    .waddr (wptr),
    .wdata (wdata),
    .raddr (rptr),
    .rdata (rdata)
  );
endmodule

// File: rtl/cfifo_chain.sv
module cfifo_chain
  import cfifo_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SLICE_DEPTH = 8,
  parameter int SLICES      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             half_n,
  input  logic             retx
);
  localparam logic SOLO = (SLICES == 1);

  xtok_t            xo_v [SLICES];
  logic [WIDTH-1:0] rd_v [SLICES];
  logic [SLICES-1:0] empty_n_v, full_n_v, half_n_v, own_w_v, own_r_v;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = (i + SLICES - 1) % SLICES;
    cfifo_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .solo    (SOLO),
      .first_n (i != 0),
      .xi      (xo_v[PREV]),
      .xo      (xo_v[i]),
      .wr      (in_valid),
      .wdata   (in_data),
      .rd      (out_ready),
      .rdata   (rd_v[i]),
      .retx    (retx),
      .empty_n (empty_n_v[i]),
      .full_n  (full_n_v[i]),
      .half_n  (half_n_v[i]),
      .own_w   (own_w_v[i]),
      .own_r   (own_r_v[i])
    );
  end

  // Composite flags: asserted (low) only when every slice asserts them.
  assign in_ready  = |full_n_v;
  assign out_valid = |empty_n_v;
  assign half_n    = &half_n_v;

  always_comb begin
    out_data = '0;
    for (int i = 0; i < SLICES; i++)
      out_data |= rd_v[i] & {WIDTH{own_r_v[i]}};
  end
endmodule

// File: rtl/cfifo_chain_chk.sv
module cfifo_chain_chk #(
  parameter int SLICES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              half_n,
  input logic              retx,
  input logic [SLICES-1:0] own_w_v,
  input logic [SLICES-1:0] own_r_v
);
  AST_WTOKEN_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(own_w_v) == 1); // R7
  AST_RTOKEN_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(own_r_v) == 1); // R7
  AST_READ_FLOWTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !out_valid && !retx |=> out_valid); // R5
  AST_WRITE_FLOWTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_ready && !retx |=> in_ready); // R6
  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid)); // R3
  AST_EMPTY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> ($past(out_ready) || $past(retx))); // R4

  if (SLICES > 1) begin : g_ring
    AST_HALF_OFF_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      half_n); // R8
  end
endmodule

bind cfifo_chain cfifo_chain_chk #(.SLICES(SLICES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .half_n    (half_n),
  .retx      (retx),
  .own_w_v   (own_w_v),
  .own_r_v   (own_r_v)
);

// File: tb/test_cfifo_chain.sv
module test_cfifo_chain;
  localparam int CLK_PERIOD = 10;
  localparam int SD   = 8;
  localparam int NS   = 3;
  localparam int CCAP = SD * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       c_iv = 0, c_ir, c_ov, c_or = 0, c_hn, c_rx = 0;
  logic [7:0] c_id = 0, c_od;
  logic       s_iv = 0, s_ir, s_ov, s_or = 0, s_hn, s_rx = 0;
  logic [7:0] s_id = 0, s_od;

  cfifo_chain #(.WIDTH(8), .SLICE_DEPTH(SD), .SLICES(NS)) i_cfifo_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(c_iv), .in_ready(c_ir), .in_data(c_id),
    .out_valid(c_ov), .out_ready(c_or), .out_data(c_od), .half_n(c_hn), .retx(c_rx));

  cfifo_chain #(.WIDTH(8), .SLICE_DEPTH(SD), .SLICES(1)) i_cfifo_solo (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir), .in_data(s_id),
    .out_valid(s_ov), .out_ready(s_or), .out_data(s_od), .half_n(s_hn), .retx(s_rx));

  int checks = 0, errors = 0;
  logic [7:0] qc[$];
  logic [7:0] qs[$];
  logic [7:0] smem [SD];
  int sw = 0;

  task automatic chk(input bit ok, input string tg, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tg, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_half(input int n);
    return !(n > SD / 2);
  endfunction

  // One cycle: check outputs against the model, drive inputs, advance the model.
  task automatic step(input bit sel, input bit v, input bit r, input bit x,
                      input logic [7:0] d, input string tg);
    @(negedge clk);
    if (!sel) begin
      chk(c_ov == (qc.size() != 0), tg, "R4 out_valid", c_ov, qc.size() != 0);
      chk(c_ir == (qc.size() < CCAP), tg, "R3 in_ready", c_ir, qc.size() < CCAP);
      chk(c_hn == 1'b1, tg, "R8 ring half_n", c_hn, 1);
      if (qc.size() != 0) chk(c_od == qc[0], tg, "R2 out_data", c_od, qc[0]);
      c_iv = v; c_or = r; c_rx = x; c_id = d;
      begin
        bit rf, wf;
        rf = r && qc.size() != 0;
        wf = v && qc.size() < CCAP;
        if (rf) void'(qc.pop_front());
        if (wf) qc.push_back(d);
      end
    end else begin
      chk(s_ov == (qs.size() != 0), tg, "R4 out_valid", s_ov, qs.size() != 0);
      chk(s_ir == (qs.size() < SD), tg, "R3 in_ready", s_ir, qs.size() < SD);
      chk(s_hn == exp_half(qs.size()), tg, "R8 half_n", s_hn, exp_half(qs.size()));
      if (qs.size() != 0) chk(s_od == qs[0], tg, "R2 out_data", s_od, qs[0]);
      s_iv = v; s_or = r; s_rx = x; s_id = d;
      if (x) begin
        qs.delete();
        for (int k = 0; k < sw; k++) qs.push_back(smem[k]);
      end else begin
        bit rf, wf;
        rf = r && qs.size() != 0;
        wf = v && qs.size() < SD;
        if (rf) void'(qs.pop_front());
        if (wf) begin
          qs.push_back(d);
          smem[sw] = d;
          sw = (sw + 1) % SD;
        end
      end
    end
  endtask

  task automatic idle_all();
    @(negedge clk);
    c_iv = 0; c_or = 0; c_rx = 0; s_iv = 0; s_or = 0; s_rx = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    c_iv = 0; c_or = 0; c_rx = 0; s_iv = 0; s_or = 0; s_rx = 0;
    qc.delete(); qs.delete(); sw = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    do_reset();
    @(negedge clk);
    chk(c_ov == 0, "R1", "out_valid", c_ov, 0);
    chk(c_ir == 1, "R1", "in_ready", c_ir, 1);
    chk(c_hn == 1, "R1", "half_n", c_hn, 1);
    chk(s_ov == 0, "R1", "solo out_valid", s_ov, 0);
    chk(s_hn == 1, "R1", "solo half_n", s_hn, 1);

    // R5 read flow-through
    step(0, 1, 0, 0, 8'hA1, "R5");
    step(0, 0, 1, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R5");
    // R4 read on empty, and read together with write into empty
    step(0, 0, 1, 0, 0, "R4");
    step(0, 1, 1, 0, 8'h5C, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 0, 0, "R4");
    // R7 fill across all slices, R3 drop at full, R6 write flow-through
    for (int i = 0; i < CCAP; i++) step(0, 1, 0, 0, 8'(i + 16), "R7");
    step(0, 1, 0, 0, 8'hEE, "R3");
    step(0, 1, 1, 0, 8'hEF, "R3");
    step(0, 0, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 8'h77, "R6");
    step(0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < CCAP; i++) step(0, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    // R10 retx ignored in a ring
    for (int i = 0; i < 200; i++)
      step(0, $urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
           8'($urandom), "R10");
    // R2 random traffic with biased phases to hit full and empty
    for (int ph = 0; ph < 6; ph++) begin
      int wb;
      wb = (ph % 2 == 0) ? 85 : 15;
      for (int i = 0; i < 500; i++)
        step(0, $urandom_range(0, 99) < wb, $urandom_range(0, 99) < (100 - wb), 0,
             8'($urandom), "R2");
    end
    idle_all();

    // Single-slice mode
    for (int i = 0; i < SD / 2 + 2; i++) step(1, 1, 0, 0, 8'(i + 64), "R8");
    step(1, 0, 1, 0, 0, "R8");
    step(1, 0, 1, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 8'(i + 100), "R9");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, "R9");
    step(1, 1, 1, 1, 8'h33, "R9");
    for (int i = 0; i < 6; i++) step(1, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 1500; i++)
      step(1, $urandom_range(0, 99) < 55, $urandom_range(0, 99) < 45,
           ($urandom_range(0, 49) == 0), 8'($urandom), "R9");
    step(1, 0, 0, 0, 0, "R9");
    idle_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule